// File: doc/BRIEF.md
# Thread Context Ring CAM Matcher

This block decides whether an incoming interrupt notification is aimed at one hardware thread and, if so, which privilege ring of that thread it reaches. The notification carries a format bit, a target block and index, an ignore bit and a logical-server id. The thread supplies one context word for each of its four rings (physical, hypervisor pool, operating system, user), each with a valid bit. The physical ring has no stored CAM. Its CAM value is built from the chip block id and the processor id.

The decision logic is combinational. A parameter can place one register stage after it. A dispatcher that visits many threads instantiates one matcher for each thread, or shares one matcher over time. Iterating over threads and recording missed notifications are done outside this block. The block has no state machine. When `REGISTERED` is 1, its only state is the output register, which holds the pair (hit, ring code).

Top module: `ringcam_top`

## Requirements
- R1: The target CAM value is `{tgt_blk, tgt_idx}`: the block in the upper `BLK_W` bits and the index in the lower `IDX_W` bits.
- R2: The physical-ring CAM is `{chip_blk, thread}`. When `tid8_mode` is 0, `thread` is `0x80 | (proc_id & 0x7F)`. When `tid8_mode` is 1, `thread` is `0x100 | proc_id`. In both cases `thread` is zero-extended to `IDX_W` bits.
- R3: With `fmt`=0 and `cam_ign`=0, the rings are tried in the order physical, pool, OS. The first ring whose valid bit is set and whose CAM equals the target wins. The user ring never matches in this format.
- R4: With `fmt`=0 and `cam_ign`=1 (logical-server addressing), `hit` is 0 whatever the ring state.
- R5: With `fmt`=1, only the user ring can match. It matches when `os_vld`=1, `os_cam` equals the target, `usr_vld`=1 and `usr_lsrv` equals `lsrv_id`. `cam_ign` has no effect in this format.
- R6: When no ring qualifies, `hit`=0 and `ring`=0.
- R7: Ring codes on `ring` are 0 for user, 1 for OS, 2 for pool and 3 for physical.
- R8: With `REGISTERED`=1 (the default), `hit` and `ring` reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| tid8_mode | input | 1 | Selects the 8-bit thread-id form of the physical CAM |
| chip_blk | input | BLK_W | Block id of this chip |
| proc_id | input | PIR_W | Processor id of the thread |
| fmt | input | 1 | Notification format: 0 = thread, 1 = user-level |
| cam_ign | input | 1 | Logical-server addressing request |
| tgt_blk | input | BLK_W | Target block |
| tgt_idx | input | IDX_W | Target index |
| lsrv_id | input | LS_W | Logical-server id of the notification |
| phys_vld | input | 1 | Physical ring context valid |
| pool_vld | input | 1 | Pool ring context valid |
| pool_cam | input | BLK_W+IDX_W | Pool ring CAM |
| os_vld | input | 1 | OS ring context valid |
| os_cam | input | BLK_W+IDX_W | OS ring CAM |
| usr_vld | input | 1 | User ring context valid |
| usr_lsrv | input | LS_W | User ring logical-server id |
| hit | output | 1 | A ring matched |
| ring | output | 2 | Code of the matched ring |

## Verification
The assertions assume that every input is stable across the sampling edge and that no input is X or Z after reset. The stimulus holds each input pattern for a full clock period and sets every input to a known value, including the inputs that the current format ignores.

To make equal CAMs likely, each random CAM is set either to a copy of the target or to a random value, with equal chances. Directed sweeps cover every combination of the valid bits, with all CAMs equal to the target. They also cover both thread-id forms and the ignore case.

// File: rtl/ringcam_pkg.sv
package ringcam_pkg;

    typedef enum logic [1:0] {
        RING_USER = 2'd0,
        RING_OS   = 2'd1,
        RING_POOL = 2'd2,
        RING_PHYS = 2'd3
    } ring_e;

endpackage

// File: rtl/ringcam_phys_cam.sv
module ringcam_phys_cam #(
    parameter int BLK_W = 4,
    parameter int IDX_W = 24,
    parameter int PIR_W = 8
) (
    input  logic                   tid8_mode,
    input  logic [BLK_W-1:0]       chip_blk,
    input  logic [PIR_W-1:0]       proc_id,
    output logic [BLK_W+IDX_W-1:0] phys_cam
);
    localparam int T7_W = PIR_W;
    localparam int T8_W = PIR_W + 1;

    logic [T7_W-1:0]  tid_short;
    logic [T8_W-1:0]  tid_long;
    logic [IDX_W-1:0] thread;

    always_comb begin
        tid_short = {1'b1, proc_id[PIR_W-2:0]};
        tid_long  = {1'b1, proc_id};
        thread    = tid8_mode ? IDX_W'(tid_long) : IDX_W'(tid_short);
        phys_cam  = {chip_blk, thread};
    end

endmodule

// File: rtl/ringcam_prio.sv
module ringcam_prio
    import ringcam_pkg::*;
(
    input  logic  fmt,
    input  logic  cam_ign,
    input  logic  phys_ok,
    input  logic  pool_ok,
    input  logic  os_ok,
    input  logic  user_ok,
    output logic  hit,
    output ring_e ring
);
    always_comb begin
        hit  = 1'b0;
        ring = RING_USER;
        if (fmt) begin
            if (user_ok) begin
                hit  = 1'b1;
                ring = RING_USER;
            end
        end else if (!cam_ign) begin
            if (phys_ok) begin
                hit  = 1'b1;
                ring = RING_PHYS;
            end else if (pool_ok) begin
                hit  = 1'b1;
                ring = RING_POOL;
            end else if (os_ok) begin
                hit  = 1'b1;
                ring = RING_OS;
            end
        end
    end

endmodule

// File: rtl/ringcam_top.sv
module ringcam_top
    import ringcam_pkg::*;
#(
    parameter int BLK_W      = 4,
    parameter int IDX_W      = 24,
    parameter int PIR_W      = 8,
    parameter int LS_W       = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tid8_mode,
    input  logic [BLK_W-1:0]       chip_blk,
    input  logic [PIR_W-1:0]       proc_id,
    input  logic                   fmt,
    input  logic                   cam_ign,
    input  logic [BLK_W-1:0]       tgt_blk,
    input  logic [IDX_W-1:0]       tgt_idx,
    input  logic [LS_W-1:0]        lsrv_id,
    input  logic                   phys_vld,
    input  logic                   pool_vld,
    input  logic [BLK_W+IDX_W-1:0] pool_cam,
    input  logic                   os_vld,
    input  logic [BLK_W+IDX_W-1:0] os_cam,
    input  logic                   usr_vld,
    input  logic [LS_W-1:0]        usr_lsrv,
    output logic                   hit,
    output logic [1:0]             ring
);
    localparam int CAM_W = BLK_W + IDX_W;

    logic [CAM_W-1:0] tgt_cam;
    logic [CAM_W-1:0] phys_cam;
    logic             phys_ok, pool_ok, os_ok, user_ok;
    logic             hit_c;
    ring_e            ring_c;

    assign tgt_cam = {tgt_blk, tgt_idx};

    ringcam_phys_cam #(.BLK_W(BLK_W), .IDX_W(IDX_W), .PIR_W(PIR_W)) u_phys (
        .tid8_mode (tid8_mode),
        .chip_blk  (chip_blk),
        .proc_id   (proc_id),
        .phys_cam  (phys_cam)
    );

    always_comb begin
        phys_ok = phys_vld && (phys_cam == tgt_cam);
        pool_ok = pool_vld && (pool_cam == tgt_cam);
        os_ok   = os_vld   && (os_cam   == tgt_cam);
        user_ok = os_ok && usr_vld && (usr_lsrv == lsrv_id);
    end

    ringcam_prio u_prio (
        .fmt     (fmt),
        .cam_ign (cam_ign),
        .phys_ok (phys_ok),
        .pool_ok (pool_ok),
        .os_ok   (os_ok),
        .user_ok (user_ok),
        .hit     (hit_c),
        .ring    (ring_c)
    );

    generate
        if (REGISTERED) begin : g_reg
            logic       hit_q;
            logic [1:0] ring_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hit_q  <= 1'b0;
                    ring_q <= 2'd0;
                end else begin
                    hit_q  <= hit_c;
                    ring_q <= ring_c;
                end
            end
            assign hit  = hit_q;
            assign ring = ring_q;
        end else begin : g_comb
            assign hit  = hit_c;
            assign ring = ring_c;
        end
    endgenerate

endmodule

// File: rtl/ringcam_chk.sv
module ringcam_chk
    import ringcam_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       fmt,
    input logic       cam_ign,
    input logic       phys_vld,
    input logic       pool_vld,
    input logic       os_vld,
    input logic       usr_vld,
    input logic       hit,
    input logic [1:0] ring
);
    logic [5:0] now_f;
    logic [5:0] d_f;
    logic d_fmt, d_ign, d_phys, d_pool, d_os, d_usr;

    assign now_f = {fmt, cam_ign, phys_vld, pool_vld, os_vld, usr_vld};

    generate
        if (REGISTERED) begin : g_dly
            logic [5:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 6'd0;
                else        q <= now_f;
            end
            assign d_f = q;
        end else begin : g_now
            assign d_f = now_f;
        end
    endgenerate

    assign {d_fmt, d_ign, d_phys, d_pool, d_os, d_usr} = d_f;

    // R4: logical-server addressing never hits
    p_ign_nohit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_fmt && d_ign) |-> !hit);

    // R5: user-level format only hits the user ring
    p_fmt1_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (d_fmt && hit) |-> (ring == RING_USER));

    // R5: user hit needs both OS and user context valid
    p_fmt1_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (d_fmt && hit) |-> (d_os && d_usr));

    // R3: a thread-format hit names a valid non-user ring
    p_f0_ring_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_fmt && hit) |-> ((ring == RING_PHYS && d_phys) ||
                             (ring == RING_POOL && d_pool) ||
                             (ring == RING_OS   && d_os)));

    // R6: no hit reports ring code 0
    p_nohit_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (ring == 2'd0));

    // R6: no valid ring means no hit
    p_novalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_phys && !d_pool && !d_os) |-> !hit);

endmodule

bind ringcam_top ringcam_chk #(.REGISTERED(REGISTERED)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt      (fmt),
    .cam_ign  (cam_ign),
    .phys_vld (phys_vld),
    .pool_vld (pool_vld),
    .os_vld   (os_vld),
    .usr_vld  (usr_vld),
    .hit      (hit),
    .ring     (ring)
);

// File: tb/ringcam_top_test.sv
module ringcam_top_test;
    localparam int BLK_W = 4;
    localparam int IDX_W = 24;
    localparam int PIR_W = 8;
    localparam int LS_W  = 8;
    localparam int CAM_W = BLK_W + IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tid8_mode = 1'b0;
    logic [BLK_W-1:0] chip_blk = '0;
    logic [PIR_W-1:0] proc_id = '0;
    logic             fmt = 1'b0;
    logic             cam_ign = 1'b0;
    logic [BLK_W-1:0] tgt_blk = '0;
    logic [IDX_W-1:0] tgt_idx = '0;
    logic [LS_W-1:0]  lsrv_id = '0;
    logic             phys_vld = 1'b0;
    logic             pool_vld = 1'b0;
    logic [CAM_W-1:0] pool_cam = '0;
    logic             os_vld = 1'b0;
    logic [CAM_W-1:0] os_cam = '0;
    logic             usr_vld = 1'b0;
    logic [LS_W-1:0]  usr_lsrv = '0;
    logic             hit;
    logic [1:0]       ring;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ringcam_top uut (
        .clk(clk), .rst_n(rst_n), .tid8_mode(tid8_mode), .chip_blk(chip_blk),
        .proc_id(proc_id), .fmt(fmt), .cam_ign(cam_ign), .tgt_blk(tgt_blk),
        .tgt_idx(tgt_idx), .lsrv_id(lsrv_id), .phys_vld(phys_vld),
        .pool_vld(pool_vld), .pool_cam(pool_cam), .os_vld(os_vld),
        .os_cam(os_cam), .usr_vld(usr_vld), .usr_lsrv(usr_lsrv),
        .hit(hit), .ring(ring)
    );

    function automatic logic [CAM_W-1:0] phys_of(logic t8, logic [BLK_W-1:0] b,
                                                 logic [PIR_W-1:0] p);
        logic [IDX_W-1:0] th;
        th = t8 ? IDX_W'(9'h100 | 9'(p)) : IDX_W'(8'h80 | 8'(p & 8'h7F));
        return {b, th};
    endfunction

    function automatic logic [2:0] model();
        logic [CAM_W-1:0] t;
        t = {tgt_blk, tgt_idx};
        if (fmt) begin
            if (os_vld && os_cam == t && usr_vld && usr_lsrv == lsrv_id)
                return {1'b1, 2'd0};
            return 3'b000;
        end
        if (cam_ign) return 3'b000;
        if (phys_vld && phys_of(tid8_mode, chip_blk, proc_id) == t) return {1'b1, 2'd3};
        if (pool_vld && pool_cam == t) return {1'b1, 2'd2};
        if (os_vld && os_cam == t) return {1'b1, 2'd1};
        return 3'b000;
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        checks++;
        if ({hit, ring} !== exp) begin
            fails++;
            $display("FAIL %s: hit/ring=%b/%0d expected %b/%0d",
                     req, hit, ring, exp[2], exp[1:0]);
        end
    endtask

    // apply current inputs, wait one edge (R8 latency), compare
    task automatic step(input string req);
        logic [2:0] e;
        e = model();
        @(negedge clk);
        check(req, e);
    endtask

    task automatic aim_at_phys();
        {tgt_blk, tgt_idx} = phys_of(tid8_mode, chip_blk, proc_id);
        pool_cam = {tgt_blk, tgt_idx};
        os_cam   = {tgt_blk, tgt_idx};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset", 3'b000);
        rst_n = 1'b1;

        // R2, R1: short thread-id form
        @(negedge clk);
        chip_blk = 4'hA; proc_id = 8'hC5; tid8_mode = 1'b0;
        tgt_blk = 4'hA; tgt_idx = 24'h0000C5 & 24'h7F | 24'h80;
        phys_vld = 1'b1;
        step("R2 tid7");
        check("R2 tid7 direct", 3'b111);
        // R2: 8-bit form misses with the same target, then hits
        tid8_mode = 1'b1;
        step("R2 tid8 miss");
        tgt_idx = 24'h1C5;
        step("R2 tid8");
        check("R2 tid8 direct", 3'b111);

        // R3, R7: sweep of ring valid bits, all CAMs equal target
        for (int m = 0; m < 16; m++) begin
            fmt = 1'b0; cam_ign = 1'b0; tid8_mode = m[0];
            aim_at_phys();
            {phys_vld, pool_vld, os_vld, usr_vld} = m[3:0];
            step("R3 sweep");
        end
        // R4: logical-server addressing with everything matching
        cam_ign = 1'b1; {phys_vld, pool_vld, os_vld, usr_vld} = 4'hF;
        step("R4 ignore");
        check("R4 ignore direct", 3'b000);
        // R5: user format sweep over OS/user valid, cam_ign set (no effect)
        for (int m = 0; m < 4; m++) begin
            fmt = 1'b1; cam_ign = 1'b1; phys_vld = 1'b1; pool_vld = 1'b1;
            lsrv_id = 8'h3C; usr_lsrv = 8'h3C;
            {os_vld, usr_vld} = m[1:0];
            step("R5 user");
        end
        usr_lsrv = 8'h3D;
        step("R5 lsrv mismatch");
        check("R5 lsrv mismatch direct", 3'b000);
        // R6: nothing valid
        fmt = 1'b0; cam_ign = 1'b0; {phys_vld, pool_vld, os_vld, usr_vld} = 4'h0;
        step("R6 none");

        // random mix (seeded)
        void'($urandom(32'h5EED));
        for (int i = 0; i < 400; i++) begin
            logic [CAM_W-1:0] t;
            tid8_mode = 1'($urandom);
            chip_blk  = BLK_W'($urandom);
            proc_id   = PIR_W'($urandom);
            fmt       = 1'($urandom);
            cam_ign   = ($urandom % 4) == 0;
            {phys_vld, pool_vld, os_vld, usr_vld} = 4'($urandom);
            t = ($urandom % 2) ? phys_of(tid8_mode, chip_blk, proc_id) : CAM_W'($urandom);
            {tgt_blk, tgt_idx} = t;
            pool_cam = ($urandom % 2) ? t : CAM_W'($urandom);
            os_cam   = ($urandom % 2) ? t : CAM_W'($urandom);
            lsrv_id  = LS_W'($urandom);
            usr_lsrv = ($urandom % 2) ? lsrv_id : LS_W'($urandom);
            step("R1 R3 R5 R6 R7 random");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: run=hung expected=complete");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule